// File: doc/BRIEF.md
# Programmable Clock Output Controller

This block drives two independent clock outputs intended for external pins. Each output picks one of five incoming clock sources (slow, master, PLL A, USB high-speed PLL, main oscillator) and divides it by a power of two between 1 and 64. Software programs each output through its own configuration register. It switches outputs on and off through a write-one-to-set register and a write-one-to-clear register, and reads back which outputs are running and which are ready.

The block is fully synchronous to one register clock. Every source is passed through a two-flop synchronizer and then oversampled. The prescaler counts rising edges of the chosen source, and the output is a registered copy of the source (divide-by-1) or of a toggling phase bit. Source switching is not glitch-protected, so the expected use is: disable the output, rewrite its configuration, enable it again. A per-output ready flag says when the output runs at its programmed settings. The flag drops when the output is disabled or reconfigured while running, and comes back once the new settings are in effect. A build parameter can replace the PLL A input with an internally halved copy.

Top module: `pclk_out_ctrl`

## Requirements
- R1: After reset, the active-status, ready-status and both configuration registers read 0 and both outputs are low.
- R2: Output i has its configuration register at address 4+i. The source select sits in bits [2:0], the prescaler exponent in bits [6:4], and bits 3 and 7 read back as 0.
- R3: A write to address 0 turns on every output whose data bit (bit i for output i) is 1. Zero bits leave the output unchanged.
- R4: A write to address 1 turns off every output whose data bit is 1. Zero bits leave the output unchanged. Address 2 reads back bit i = 1 while output i is on.
- R5: While an output is off, its pin is low and its ready bit is 0, from the cycle after it is turned off.
- R6: Source select 0..4 chooses slow clock, master clock, PLL A, USB PLL and main clock in that order. With prescaler exponent n in 0..6, the output period is 2^n periods of the chosen source.
- R7: Prescaler value 7 divides by 64, the same as value 6.
- R8: Address 3 reads back bit i = ready of output i. After an output is turned on, ready rises at the first rising edge of the selected source seen by the block.
- R9: A configuration write to an output that is on clears its ready bit at the write edge. The new prescaler ratio takes effect at the next divided-clock toggle, and ready returns at that same toggle.
- R10: Source select values 5..7 choose no source: the output stays low and ready stays 0 even while the output is on.
- R11: The two outputs are independent. Turning on, turning off or configuring one output does not change the other's pin or status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| src_slow | input | 1 | Slow clock source (select 0) |
| src_mclk | input | 1 | Master clock source (select 1) |
| src_plla | input | 1 | PLL A source (select 2) |
| src_utmi | input | 1 | USB PLL source (select 3) |
| src_main | input | 1 | Main oscillator source (select 4) |
| pck_out | output | 2 | Programmable clock outputs, bit i for output i |

## Verification
Register writes take effect at the clock edge that samples bus_we. Read data is combinational, so the bench reads status in the half cycle after a write. This is where the active bit must already show and where ready must already be 0 after an enable or a reconfiguring write. Ready returns only after the two-flop synchronizer, one edge detect and either one source edge or one divided toggle. The bench therefore polls it with a bound derived from the source period and does not check a fixed cycle for it. Output periods are measured in clk cycles between two consecutive rising edges of the pin, sampled at the falling clock edge. The synchronizer and output register add a constant delay, so the measured period must equal 2^n times the source period exactly.

// File: rtl/pco_pkg.sv
package pco_pkg;
  localparam int NSRC     = 5;
  localparam int SRC_PLLA = 2;
  localparam int A_ENA    = 0;
  localparam int A_DIS    = 1;
  localparam int A_ACT    = 2;
  localparam int A_RDY    = 3;
  localparam int A_CFG0   = 4;
  localparam int PRE_MAX  = 6;
  localparam int CNT_W    = PRE_MAX;

  function automatic logic [2:0] pre_clamp(input logic [2:0] p);
    return (p > 3'(PRE_MAX)) ? 3'(PRE_MAX) : p;
  endfunction

  function automatic logic [CNT_W-1:0] half_count(input logic [2:0] n);
    if (n == 3'd0) return CNT_W'(1);
    return CNT_W'(1) << (n - 3'd1);
  endfunction
endpackage

// File: rtl/pco_src_sync.sv
module pco_src_sync
  import pco_pkg::*;
#(
  parameter int N         = NSRC,
  parameter bit PLLA_HALF = 1'b0
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_raw,
  output logic [N-1:0] src_s
);
  logic [N-1:0] st1, st2;

  for (genvar g = 0; g < N; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1[g] <= 1'b0;
        st2[g] <= 1'b0;
      end else begin
        st1[g] <= src_raw[g];
        st2[g] <= st1[g];
      end
    end
  end

  if (PLLA_HALF) begin : g_half
    logic pl_d, pl_half;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pl_d    <= 1'b0;
        pl_half <= 1'b0;
      end else begin
        pl_d <= st2[SRC_PLLA];
        if (st2[SRC_PLLA] && !pl_d) pl_half <= ~pl_half;
      end
    end
    always_comb begin
      src_s = st2;
      src_s[SRC_PLLA] = pl_half;
    end
  end else begin : g_full
    assign src_s = st2;
  end
endmodule

// File: rtl/pco_regs.sv
module pco_regs
  import pco_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 8,
  parameter int AW  = 3
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  input  logic [NCH-1:0]      ready,
  output logic [NCH-1:0]      en,
  output logic [NCH-1:0][2:0] sel,
  output logic [NCH-1:0][2:0] pre,
  output logic [NCH-1:0]      cfg_wr,
  output logic [DW-1:0]       rdata
);
  logic wr_ena, wr_dis;
  assign wr_ena = we && (addr == AW'(A_ENA));
  assign wr_dis = we && (addr == AW'(A_DIS));

  for (genvar i = 0; i < NCH; i++) begin : g_cfg
    assign cfg_wr[i] = we && (addr == AW'(A_CFG0 + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel[i] <= 3'd0;
        pre[i] <= 3'd0;
      end else if (cfg_wr[i]) begin
        sel[i] <= wdata[2:0];
        pre[i] <= wdata[6:4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= '0;
    else if (wr_ena) en <= en | wdata[NCH-1:0];
    else if (wr_dis) en <= en & ~wdata[NCH-1:0];
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(A_ACT)) rdata[NCH-1:0] = en;
    if (addr == AW'(A_RDY)) rdata[NCH-1:0] = ready;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(A_CFG0 + i)) rdata[6:0] = {pre[i], 1'b0, sel[i]};
    end
  end

  // R3
  ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ena |=> ((en & $past(wdata[NCH-1:0])) == $past(wdata[NCH-1:0])));
  // R4
  dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> ((en & $past(wdata[NCH-1:0])) == '0));
  // R11
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ena && !wr_dis) |=> $stable(en));
endmodule

// File: rtl/pco_chan.sv
module pco_chan
  import pco_pkg::*;
#(
  parameter int N = NSRC
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_s,
  input  logic         en,
  input  logic         cfg_wr,
  input  logic [2:0]   sel,
  input  logic [2:0]   pre,
  output logic         clk_out,
  output logic         ready
);
  logic             src_sel, sel_d;
  logic             src_rise, div_last, div_tick;
  logic             phase, pending;
  logic [2:0]       act_n;
  logic [CNT_W-1:0] cnt, half;

  assign src_sel  = (int'(sel) < N) ? src_s[sel] : 1'b0;
  assign src_rise = src_sel && !sel_d;
  assign half     = half_count(act_n);
  assign div_last = (act_n == 3'd0) || (cnt == half - CNT_W'(1));
  assign div_tick = en && src_rise && div_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_d <= 1'b0;
    else        sel_d <= src_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      phase   <= 1'b0;
      clk_out <= 1'b0;
      ready   <= 1'b0;
      pending <= 1'b0;
      act_n   <= 3'd0;
    end else if (!en) begin
      cnt     <= '0;
      phase   <= 1'b0;
      clk_out <= 1'b0;
      ready   <= 1'b0;
      pending <= 1'b0;
      act_n   <= pre_clamp(pre);
    end else begin
      if (src_rise) begin
        if (div_last) begin
          cnt   <= '0;
          phase <= ~phase;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
      clk_out <= (act_n == 3'd0) ? src_sel : phase;
      if (cfg_wr) begin
        pending <= 1'b1;
        ready   <= 1'b0;
      end else if (pending) begin
        if (div_tick) begin
          act_n   <= pre_clamp(pre);
          cnt     <= '0;
          pending <= 1'b0;
          ready   <= 1'b1;
        end
      end else if (src_rise) begin
        ready <= 1'b1;
      end
    end
  end

  // R5
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!clk_out && !ready));
  // R9
  cfg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cfg_wr) |=> !ready);
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < half);
  // R8
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(src_rise));
endmodule

// File: rtl/pclk_out_ctrl.sv
module pclk_out_ctrl
  import pco_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int DW        = 8,
  parameter int AW        = 3,
  parameter bit PLLA_HALF = 1'b0
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic           src_slow,
  input  logic           src_mclk,
  input  logic           src_plla,
  input  logic           src_utmi,
  input  logic           src_main,
  output logic [NCH-1:0] pck_out
);
  logic [NSRC-1:0]      src_raw, src_s;
  logic [NCH-1:0]       en, cfg_wr, ready;
  logic [NCH-1:0][2:0]  sel, pre;

  assign src_raw = {src_main, src_utmi, src_plla, src_mclk, src_slow};

  pco_src_sync #(.N(NSRC), .PLLA_HALF(PLLA_HALF)) u_sync (
    .clk(clk), .rst_n(rst_n), .src_raw(src_raw), .src_s(src_s)
  );

  pco_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .ready(ready), .en(en), .sel(sel), .pre(pre), .cfg_wr(cfg_wr),
    .rdata(bus_rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pco_chan #(.N(NSRC)) u_ch (
      .clk(clk), .rst_n(rst_n), .src_s(src_s), .en(en[i]),
      .cfg_wr(cfg_wr[i]), .sel(sel[i]), .pre(pre[i]),
      .clk_out(pck_out[i]), .ready(ready[i])
    );
  end
endmodule

// File: tb/pclk_out_ctrl_test.sv
module pclk_out_ctrl_test;
  localparam int HS = 40, HM = 3, HP = 4, HU = 5, HN = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       s_slow = 1'b0, s_mclk = 1'b0, s_plla = 1'b0, s_utmi = 1'b0, s_main = 1'b0;
  logic [1:0] pck_out;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  initial begin #7; forever #(HS*20) s_slow = ~s_slow; end
  initial begin #7; forever #(HM*20) s_mclk = ~s_mclk; end
  initial begin #7; forever #(HP*20) s_plla = ~s_plla; end
  initial begin #7; forever #(HU*20) s_utmi = ~s_utmi; end
  initial begin #7; forever #(HN*20) s_main = ~s_main; end

  pclk_out_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_slow(s_slow), .src_mclk(s_mclk), .src_plla(s_plla),
    .src_utmi(s_utmi), .src_main(s_main), .pck_out(pck_out)
  );

  function automatic int src_period(input int s);
    case (s)
      0: return 2*HS;
      1: return 2*HM;
      2: return 2*HP;
      3: return 2*HU;
      4: return 2*HN;
      default: return 0;
    endcase
  endfunction

  function automatic int div_of(input int p);
    return 1 << ((p > 6) ? 6 : p);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = 3'(a);
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic wait_ready(input int ch, input int limit, output int cyc);
    int v;
    cyc = -1;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      rd(3, v);
      if (v[ch]) begin cyc = k; break; end
    end
  endtask

  task automatic measure(input int ch, output int per);
    int c = 0;
    bit prev;
    bit seen = 1'b0;
    per = -1;
    @(negedge clk);
    prev = pck_out[ch];
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (seen) c++;
      if (pck_out[ch] && !prev) begin
        if (seen) begin per = c; break; end
        seen = 1'b1;
        c = 0;
      end
      prev = pck_out[ch];
    end
  endtask

  task automatic t_reset();
    int v;
    rd(2, v); check(v == 0, "R1 active after reset", v, 0);
    rd(3, v); check(v == 0, "R1 ready after reset", v, 0);
    rd(4, v); check(v == 0, "R1 cfg0 after reset", v, 0);
    rd(5, v); check(v == 0, "R1 cfg1 after reset", v, 0);
    check(pck_out == 2'b00, "R1 pins after reset", int'(pck_out), 0);
  endtask

  task automatic t_cfg_readback();
    int v;
    wr(4, 8'hFB); rd(4, v); check(v == 8'h73, "R2 cfg0 readback", v, 8'h73);
    wr(5, 8'h21); rd(5, v); check(v == 8'h21, "R2 cfg1 readback", v, 8'h21);
    rd(4, v); check(v == 8'h73, "R11 cfg0 untouched", v, 8'h73);
  endtask

  task automatic t_enable_disable();
    int v;
    wr(1, 3);
    wr(0, 1); rd(2, v); check(v == 1, "R3 set out0", v, 1);
    wr(0, 0); rd(2, v); check(v == 1, "R3 zero write no effect", v, 1);
    wr(0, 2); rd(2, v); check(v == 3, "R3 set out1 keeps out0", v, 3);
    wr(1, 0); rd(2, v); check(v == 3, "R4 zero write no effect", v, 3);
    wr(1, 1); rd(2, v); check(v == 2, "R4 clear out0", v, 2);
    wr(1, 2); rd(2, v); check(v == 0, "R4 clear out1", v, 0);
  endtask

  task automatic t_period(input int ch, input int s, input int p, input string tag);
    int cyc, per, exp;
    wr(1, 1 << ch);
    wr(4 + ch, (p << 4) | s);
    wr(0, 1 << ch);
    wait_ready(ch, src_period(s) + 10, cyc);
    check(cyc >= 0, {tag, " ready"}, cyc, 0);
    measure(ch, per);
    exp = div_of(p) * src_period(s);
    check(per == exp, {tag, " period"}, per, exp);
    wr(1, 1 << ch);
  endtask

  task automatic t_off_low();
    int v;
    bit hi = 1'b0;
    wr(4, 8'h01); wr(0, 1);
    wait_ready(0, 20, v);
    wr(1, 1);
    @(negedge clk);
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (pck_out[0]) hi = 1'b1;
    end
    check(!hi, "R5 pin low while off", int'(hi), 0);
    rd(3, v); check(v[0] == 1'b0, "R5 ready low while off", v, 0);
  endtask

  task automatic t_ready_on_enable();
    int v, cyc;
    wr(4, 8'h30);
    wr(0, 1);
    rd(3, v); check(v[0] == 1'b0, "R8 ready low at enable", v, 0);
    wait_ready(0, src_period(0) + 8, cyc);
    check(cyc >= 0, "R8 ready within one source period", cyc, src_period(0));
    wr(1, 1);
  endtask

  task automatic t_reconfig();
    int v, cyc, per;
    wr(4, 8'h11); wr(0, 1);
    wait_ready(0, 20, cyc);
    wr(4, 8'h31);
    rd(3, v); check(v[0] == 1'b0, "R9 ready cleared by live write", v, 0);
    wait_ready(0, 200, cyc);
    check(cyc >= 0, "R9 ready returns", cyc, 0);
    measure(0, per);
    check(per == 48, "R9 new ratio in effect", per, 48);
    wr(1, 1);
  endtask

  task automatic t_reserved();
    int v;
    bit hi = 1'b0;
    wr(5, 8'h06); wr(0, 2);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (pck_out[1]) hi = 1'b1;
    end
    check(!hi, "R10 no source pin low", int'(hi), 0);
    rd(3, v); check(v[1] == 1'b0, "R10 no source ready low", v, 0);
    wr(1, 2);
  endtask

  task automatic t_independent();
    int v, cyc, per;
    bit hi = 1'b0;
    wr(5, 8'h13); wr(0, 2);
    wait_ready(1, 30, cyc);
    wr(4, 8'h02);
    rd(3, v); check(v[1] == 1'b1, "R11 cfg0 write leaves out1 ready", v, 2);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (pck_out[0]) hi = 1'b1;
    end
    check(!hi, "R11 out0 stays low", int'(hi), 0);
    measure(1, per);
    check(per == 20, "R11 out1 period", per, 20);
    wr(1, 2);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_cfg_readback();
    t_enable_disable();
    t_period(0, 0, 0, "R6 slow /1");
    t_period(0, 1, 2, "R6 master /4");
    t_period(1, 2, 1, "R6 plla /2");
    t_period(1, 3, 3, "R6 utmi /8");
    t_period(0, 4, 0, "R6 main /1");
    t_period(1, 1, 6, "R6 master /64");
    t_period(0, 1, 7, "R7 reserved prescaler /64");
    t_off_low();
    t_ready_on_enable();
    t_reconfig();
    t_reserved();
    t_independent();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule